// File: doc/BRIEF.md
# Single-Step and Resume Flag Sequencer

This block keeps the trap flag (TF) and the resume flag (RF) of a processor core in step with instruction boundaries. When the core retires an instruction, the block decides whether a single-step trap is due and asks for it. It holds an arming bit so that the instruction which turns TF on is never trapped itself. When a single-step trap and an external interrupt fall due together, the trap wins and the interrupt is looked at again one cycle later. For every event that enters a handler, the block also works out the RF value to be pushed with the flags image.

The core drives plain control strobes. `retire_i` marks an instruction completing. A flags write that rides on that retirement acts like a flag pop: it can change TF, but it can never change RF. `restore_i` models a task switch or an interrupt return, and it loads both flags from the saved image. `bp_check_i` marks the code-breakpoint check at the start of an instruction. An event descriptor (`evt_valid_i`, `evt_kind_i`, `rep_more_i`) asks for the saved RF value. There is no streaming data path, so there is no valid/ready handshake: every strobe is taken in the cycle it is high. Restore has priority over retire, and retire has priority over a software-interrupt event.

Top module: `ssrf_seq`

## Requirements
- R1: After reset, `tf_o`, `rf_o`, `step_req_o`, `irq_take_o` and `bp_fault_o` are all 0.
- R2: A retirement that writes TF from 0 to 1 raises no `step_req_o`. The next retirement raises `step_req_o` combinationally, in its own cycle.
- R3: A single-step trap clears TF on the following clock edge. The retirement after that raises no trap unless TF has been set again.
- R4: A retirement that starts with the trap armed raises `step_req_o`, even if its own flags write clears TF.
- R5: `restore_i` loads `tf_o` and `rf_o` from `restore_tf_i` and `restore_rf_i` on the next edge. A TF restored as 1 is armed at once, so the first retirement after the restore traps.
- R6: An event of kind software interrupt (`evt_kind_i` = 4) clears TF and disarms the trap. The next retirement then raises no trap.
- R7: `irq_take_o` is 0 in any cycle where `step_req_o` is 1. In the cycle after a single-step trap, `irq_take_o` equals `ext_irq_i`. On a retirement without a trap, `irq_take_o` equals `ext_irq_i`. In any other cycle it is 0.
- R8: On `bp_check_i`, `bp_fault_o` is `bp_match_i` AND NOT RF. RF reads 0 after that edge.
- R9: The saved RF value `saved_rf_o` depends on `evt_kind_i`:
  - kind 0 (ordinary fault) gives 1;
  - kind 1 (instruction-breakpoint fault) gives the live RF;
  - kind 2 (trap) and kind 3 (hardware interrupt) give 1 when `rep_more_i` is set, and the live RF otherwise;
  - kind 4 (software interrupt) gives 0.
- R10: A flags write carried on a retirement leaves RF unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| retire_i | input | 1 | Instruction completes this cycle |
| flag_wr_i | input | 1 | The retiring instruction writes TF |
| flag_wr_tf_i | input | 1 | New TF value for the flags write |
| restore_i | input | 1 | Task switch or interrupt return loads both flags |
| restore_tf_i | input | 1 | TF value from the saved image |
| restore_rf_i | input | 1 | RF value from the saved image |
| bp_check_i | input | 1 | Code-breakpoint check point of an instruction |
| bp_match_i | input | 1 | Instruction address hits a code breakpoint |
| evt_valid_i | input | 1 | Handler-entry event present |
| evt_kind_i | input | 3 | Event kind: 0 fault, 1 breakpoint fault, 2 trap, 3 hw int, 4 sw int |
| rep_more_i | input | 1 | Event follows a non-final repeated-string iteration |
| ext_irq_i | input | 1 | External interrupt pending |
| step_req_o | output | 1 | Single-step trap request |
| irq_take_o | output | 1 | External interrupt accepted |
| bp_fault_o | output | 1 | Instruction-breakpoint fault |
| tf_o | output | 1 | Live trap flag |
| rf_o | output | 1 | Live resume flag |
| saved_rf_o | output | 1 | RF value to push for the current event |

## Verification
The bench targets the one-instruction delay in several ways:
- It checks that the instruction which sets TF is not trapped. A design that traps on it would step one instruction early.
- It checks that an instruction which clears TF while armed is still trapped. A design that tests the live TF instead would miss this trap.
- It restores TF through a task switch and checks that the first retirement traps. A design that delays this trap would lose a step.

It also checks the trap/interrupt collision from both sides. A design that lets the interrupt win would step no more. A design that forgets to re-sample the interrupt would drop it. Finally, it sweeps every event kind, repeat flag and RF value through the saved-RF table, and it checks that a flags write cannot alter RF.

// File: rtl/ssrf_pkg.sv
package ssrf_pkg;
  localparam int KIND_W = 3;

  typedef enum logic [KIND_W-1:0] {
    EVK_FAULT    = 3'd0,
    EVK_BP_FAULT = 3'd1,
    EVK_TRAP     = 3'd2,
    EVK_HW_INT   = 3'd3,
    EVK_SW_INT   = 3'd4
  } evt_kind_e;
endpackage

// File: rtl/ssrf_tf_track.sv
module ssrf_tf_track (
  input  logic clk,
  input  logic rst_n,
  input  logic retire_i,
  input  logic flag_wr_i,
  input  logic flag_wr_tf_i,
  input  logic restore_i,
  input  logic restore_tf_i,
  input  logic sw_evt_i,
  output logic tf_o,
  output logic step_fire_o
);
  logic tf_q, armed_q, tf_next;

  // Arming bit: latched from TF as it stands after an instruction,
  // and consumed at the end of the next one.
  assign tf_next     = flag_wr_i ? flag_wr_tf_i : tf_q;
  assign step_fire_o = retire_i && armed_q && !restore_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tf_q    <= 1'b0;
      armed_q <= 1'b0;
    end else if (restore_i) begin
      tf_q    <= restore_tf_i;
      armed_q <= restore_tf_i;
    end else if (retire_i) begin
      if (armed_q) begin
        tf_q    <= 1'b0;
        armed_q <= 1'b0;
      end else begin
        tf_q    <= tf_next;
        armed_q <= tf_next;
      end
    end else if (sw_evt_i) begin
      tf_q    <= 1'b0;
      armed_q <= 1'b0;
    end
  end

  assign tf_o = tf_q;
endmodule

// File: rtl/ssrf_rf_track.sv
module ssrf_rf_track (
  input  logic clk,
  input  logic rst_n,
  input  logic restore_i,
  input  logic restore_rf_i,
  input  logic bp_check_i,
  input  logic bp_match_i,
  output logic rf_o,
  output logic bp_fault_o
);
  logic rf_q;

  assign bp_fault_o = bp_check_i && bp_match_i && !rf_q;

  always_ff @(posedge clk) begin
    if (!rst_n)          rf_q <= 1'b0;
    else if (restore_i)  rf_q <= restore_rf_i;
    else if (bp_check_i) rf_q <= 1'b0;
  end

  assign rf_o = rf_q;
endmodule

// File: rtl/ssrf_rf_table.sv
module ssrf_rf_table
  import ssrf_pkg::*;
(
  input  logic              rf_i,
  input  logic [KIND_W-1:0] kind_i,
  input  logic              rep_more_i,
  output logic              saved_rf_o
);
  always_comb begin
    unique case (kind_i)
      EVK_FAULT:             saved_rf_o = 1'b1;
      EVK_BP_FAULT:          saved_rf_o = rf_i;
      EVK_TRAP, EVK_HW_INT:  saved_rf_o = rep_more_i | rf_i;
      EVK_SW_INT:            saved_rf_o = 1'b0;
      default:               saved_rf_o = rf_i;
    endcase
  end
endmodule

// File: rtl/ssrf_irq_order.sv
module ssrf_irq_order (
  input  logic clk,
  input  logic rst_n,
  input  logic retire_i,
  input  logic step_fire_i,
  input  logic ext_irq_i,
  output logic irq_take_o
);
  logic resample_q;

  always_ff @(posedge clk) begin
    if (!rst_n) resample_q <= 1'b0;
    else        resample_q <= step_fire_i;
  end

  assign irq_take_o = ext_irq_i && !step_fire_i && (retire_i || resample_q);
endmodule

// File: rtl/ssrf_seq.sv
module ssrf_seq
  import ssrf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              retire_i,
  input  logic              flag_wr_i,
  input  logic              flag_wr_tf_i,
  input  logic              restore_i,
  input  logic              restore_tf_i,
  input  logic              restore_rf_i,
  input  logic              bp_check_i,
  input  logic              bp_match_i,
  input  logic              evt_valid_i,
  input  logic [KIND_W-1:0] evt_kind_i,
  input  logic              rep_more_i,
  input  logic              ext_irq_i,
  output logic              step_req_o,
  output logic              irq_take_o,
  output logic              bp_fault_o,
  output logic              tf_o,
  output logic              rf_o,
  output logic              saved_rf_o
);
  logic sw_evt, step_fire, rf_live;

  assign sw_evt = evt_valid_i && (evt_kind_i == EVK_SW_INT);

  ssrf_tf_track u_tf (
    .clk(clk), .rst_n(rst_n), .retire_i(retire_i), .flag_wr_i(flag_wr_i),
    .flag_wr_tf_i(flag_wr_tf_i), .restore_i(restore_i),
    .restore_tf_i(restore_tf_i), .sw_evt_i(sw_evt),
    .tf_o(tf_o), .step_fire_o(step_fire)
  );

  ssrf_rf_track u_rf (
    .clk(clk), .rst_n(rst_n), .restore_i(restore_i),
    .restore_rf_i(restore_rf_i), .bp_check_i(bp_check_i),
    .bp_match_i(bp_match_i), .rf_o(rf_live), .bp_fault_o(bp_fault_o)
  );

  ssrf_rf_table u_tab (
    .rf_i(rf_live), .kind_i(evt_kind_i), .rep_more_i(rep_more_i),
    .saved_rf_o(saved_rf_o)
  );

  ssrf_irq_order u_irq (
    .clk(clk), .rst_n(rst_n), .retire_i(retire_i), .step_fire_i(step_fire),
    .ext_irq_i(ext_irq_i), .irq_take_o(irq_take_o)
  );

  assign step_req_o = step_fire;
  assign rf_o       = rf_live;
endmodule

// File: rtl/ssrf_seq_chk.sv
module ssrf_seq_chk
  import ssrf_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              retire_i,
  input logic              flag_wr_i,
  input logic              flag_wr_tf_i,
  input logic              restore_i,
  input logic              restore_tf_i,
  input logic              restore_rf_i,
  input logic              bp_check_i,
  input logic              evt_valid_i,
  input logic [KIND_W-1:0] evt_kind_i,
  input logic              ext_irq_i,
  input logic              step_req_o,
  input logic              irq_take_o,
  input logic              tf_o,
  input logic              rf_o,
  input logic              saved_rf_o
);
  assert_no_trap_on_setter_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (retire_i && flag_wr_i && flag_wr_tf_i && !tf_o && !restore_i) |-> !step_req_o);

  assert_trap_clears_tf_R3: assert property (@(posedge clk) disable iff (!rst_n)
    step_req_o |=> !tf_o);

  assert_restore_loads_R5: assert property (@(posedge clk) disable iff (!rst_n)
    restore_i |=> (tf_o == $past(restore_tf_i)) && (rf_o == $past(restore_rf_i)));

  assert_step_beats_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
    step_req_o |-> !irq_take_o);

  assert_irq_resampled_R7: assert property (@(posedge clk) disable iff (!rst_n)
    step_req_o |=> (irq_take_o == ext_irq_i));

  assert_bp_clears_rf_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bp_check_i && !restore_i) |=> !rf_o);

  assert_fault_saves_one_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid_i && evt_kind_i == EVK_FAULT) |-> saved_rf_o);

  assert_swint_saves_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid_i && evt_kind_i == EVK_SW_INT) |-> !saved_rf_o);

  assert_pop_keeps_rf_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (retire_i && flag_wr_i && !restore_i && !bp_check_i) |=> (rf_o == $past(rf_o)));
endmodule

bind ssrf_seq ssrf_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .retire_i(retire_i), .flag_wr_i(flag_wr_i),
  .flag_wr_tf_i(flag_wr_tf_i), .restore_i(restore_i),
  .restore_tf_i(restore_tf_i), .restore_rf_i(restore_rf_i),
  .bp_check_i(bp_check_i), .evt_valid_i(evt_valid_i),
  .evt_kind_i(evt_kind_i), .ext_irq_i(ext_irq_i),
  .step_req_o(step_req_o), .irq_take_o(irq_take_o), .tf_o(tf_o),
  .rf_o(rf_o), .saved_rf_o(saved_rf_o)
);

// File: tb/ssrf_seq_test.sv
module ssrf_seq_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic retire_i = 0, flag_wr_i = 0, flag_wr_tf_i = 0;
  logic restore_i = 0, restore_tf_i = 0, restore_rf_i = 0;
  logic bp_check_i = 0, bp_match_i = 0, evt_valid_i = 0;
  logic [2:0] evt_kind_i = 3'd0;
  logic rep_more_i = 0, ext_irq_i = 0;
  logic step_req_o, irq_take_o, bp_fault_o, tf_o, rf_o, saved_rf_o;
  int n_chk = 0, n_err = 0;
  bit done = 0;

  always #10 clk = ~clk;

  ssrf_seq uut (.*);

  task automatic chk(string req, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle();
    retire_i = 0; flag_wr_i = 0; flag_wr_tf_i = 0; restore_i = 0;
    restore_tf_i = 0; restore_rf_i = 0; bp_check_i = 0; bp_match_i = 0;
    evt_valid_i = 0; evt_kind_i = 3'd0; rep_more_i = 0; ext_irq_i = 0;
  endtask

  // Passes one rising edge and returns at the next falling edge with inputs idle.
  task automatic edge_pass();
    @(negedge clk);
    idle();
    #1;
  endtask

  task automatic do_restore(logic t, logic r);
    restore_i = 1; restore_tf_i = t; restore_rf_i = r;
    edge_pass();
  endtask

  initial begin
    #200000;
    n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk("R1 tf", tf_o, 0);
    chk("R1 rf", rf_o, 0);
    chk("R1 step", step_req_o, 0);
    chk("R1 irq", irq_take_o, 0);
    chk("R1 bp", bp_fault_o, 0);

    // R2/R3: set TF, trap after the next instruction only
    retire_i = 1; flag_wr_i = 1; flag_wr_tf_i = 1; #1;
    chk("R2 no trap on setter", step_req_o, 0);
    edge_pass();
    chk("R2 tf set", tf_o, 1);
    retire_i = 1; #1;
    chk("R2 trap on next retire", step_req_o, 1);
    edge_pass();
    chk("R3 tf cleared by trap", tf_o, 0);
    retire_i = 1; #1;
    chk("R3 no further trap", step_req_o, 0);
    edge_pass();

    // R4: armed instruction that clears TF still traps
    retire_i = 1; flag_wr_i = 1; flag_wr_tf_i = 1; edge_pass();
    retire_i = 1; flag_wr_i = 1; flag_wr_tf_i = 0; #1;
    chk("R4 trap despite clear", step_req_o, 1);
    edge_pass();
    chk("R4 tf low", tf_o, 0);

    // R5: restore arms at once
    do_restore(1, 1);
    chk("R5 tf loaded", tf_o, 1);
    chk("R5 rf loaded", rf_o, 1);
    retire_i = 1; #1;
    chk("R5 first retire traps", step_req_o, 1);
    edge_pass();
    do_restore(0, 0);
    chk("R5 rf loaded 0", rf_o, 0);
    retire_i = 1; #1;
    chk("R5 no trap with tf 0", step_req_o, 0);
    edge_pass();

    // R6: software interrupt clears TF
    retire_i = 1; flag_wr_i = 1; flag_wr_tf_i = 1; edge_pass();
    evt_valid_i = 1; evt_kind_i = 3'd4; edge_pass();
    chk("R6 tf cleared", tf_o, 0);
    retire_i = 1; #1;
    chk("R6 no trap after sw int", step_req_o, 0);
    edge_pass();

    // R7: ordering with external interrupt
    retire_i = 1; flag_wr_i = 1; flag_wr_tf_i = 1; edge_pass();
    retire_i = 1; ext_irq_i = 1; #1;
    chk("R7 step wins", step_req_o, 1);
    chk("R7 irq held off", irq_take_o, 0);
    edge_pass();
    ext_irq_i = 1; #1;
    chk("R7 irq resampled", irq_take_o, 1);
    edge_pass();
    ext_irq_i = 1; #1;
    chk("R7 no boundary no irq", irq_take_o, 0);
    retire_i = 1; #1;
    chk("R7 irq on plain retire", irq_take_o, 1);
    edge_pass();
    retire_i = 1; flag_wr_i = 1; flag_wr_tf_i = 1; edge_pass();
    retire_i = 1; edge_pass();
    chk("R7 resample irq dropped", irq_take_o, 0);

    // R8: RF masks breakpoint once, then cleared
    do_restore(0, 1);
    bp_check_i = 1; bp_match_i = 1; #1;
    chk("R8 masked by rf", bp_fault_o, 0);
    edge_pass();
    chk("R8 rf cleared", rf_o, 0);
    bp_check_i = 1; bp_match_i = 1; #1;
    chk("R8 fault raised", bp_fault_o, 1);
    edge_pass();
    bp_check_i = 1; bp_match_i = 0; #1;
    chk("R8 no match no fault", bp_fault_o, 0);
    edge_pass();

    // R10: flags write leaves RF alone
    do_restore(0, 1);
    retire_i = 1; flag_wr_i = 1; flag_wr_tf_i = 1; edge_pass();
    chk("R10 rf kept", rf_o, 1);
    chk("R10 tf written", tf_o, 1);
    do_restore(0, 0);
    retire_i = 1; flag_wr_i = 1; flag_wr_tf_i = 0; edge_pass();
    chk("R10 rf stays 0", rf_o, 0);

    // R9: full sweep of the saved-RF table
    for (int rv = 0; rv < 2; rv++) begin
      do_restore(0, rv[0]);
      for (int k = 0; k < 5; k++) begin
        for (int rp = 0; rp < 2; rp++) begin
          logic exp;
          case (k)
            0: exp = 1'b1;
            1: exp = rv[0];
            2, 3: exp = rv[0] | rp[0];
            default: exp = 1'b0;
          endcase
          evt_valid_i = 1; evt_kind_i = 3'(k); rep_more_i = rp[0]; #1;
          chk($sformatf("R9 kind%0d rep%0d rf%0d", k, rp, rv), saved_rf_o, exp);
          edge_pass();
        end
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule